// File: doc/BRIEF.md
# I2C Master Byte Engine

This block drives an I2C bus as a master, one byte at a time. After a start command, the first byte placed in the buffer is sent as a 7-bit slave address plus a direction bit taken from a mode input. The slave's acknowledge then selects what the engine does next. With a write direction it stays parked and keeps SDA, waiting for the next byte. With a read direction that was acknowledged it releases SDA and clocks bytes in from the slave with no further write. With a refused address it keeps SDA and still accepts data bytes to send.

SCL comes from a free-running tick divider. Each SCL low phase and each high phase lasts `HALF_DIV` clocks. The divider restarts whenever a transfer, START, STOP or resume begins. SDA and SCL are open-drain: an output-enable of 1 pulls the line low.

Received bytes land in a single buffer. If a new byte completes while the previous one is still unread, the engine flags an overrun, keeps SCL low and holds the new byte. A later buffer read releases it. Status flags are sticky and are cleared by writing 1 to them.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy` and all four flags are 0, and the bus stays released while idle.
- R2: `start_cmd` on an idle bus pulls SDA low while SCL is high, then pulls SCL low. `stop_cmd` while parked releases SCL first and then SDA, with SDA rising while SCL is high.
- R3: The first buffer write after START sends `buf_wdata[6:0]` MSB first, followed by `mode_rd` as the eighth bit.
- R4: Each SCL high phase and each SCL low phase within a byte lasts `HALF_DIV` clocks. The master changes SDA only while SCL is low, except for START and STOP.
- R5: A buffer write is accepted only while parked and not busy, and it raises `busy` on the next clock. Writes made while busy do not change the byte on the wire.
- R6: At the end of a sent byte's ninth clock, `nack_flag` is set if SDA was sampled high, `txd_flag` is set, `busy` clears (except after an acknowledged read address), and the master keeps SDA low.
- R7: After an acknowledged read address, the engine releases SDA, keeps `busy` at 1, and shifts in bytes MSB first, sampling at each SCL rising edge.
- R8: Each received byte is copied to `buf_rdata` and sets `rxd_flag`. The ninth bit driven is `rx_nack` as sampled at byte completion (0 means SDA low, an acknowledge). After an acknowledge the engine reads the next byte. After a refusal it parks with `busy` at 0 and SDA low.
- R9: If a byte completes while the buffer is still unread, `ovr_flag` is set, SCL stays low and `buf_rdata` keeps the older byte. A later `buf_rd` returns the older byte, loads the held one, and continues with its acknowledge.
- R10: A `buf_rd` in the same cycle that a byte completes counts as reading first, so no overrun occurs and the new byte is loaded.
- R11: `flag_clr` bit 0 clears `txd_flag`, bit 1 clears `rxd_flag`, bit 2 clears `nack_flag` and bit 3 clears `ovr_flag`. A flag being set in the same cycle stays 1.
- R12: After a refused read address, the engine parks with SDA low, `busy` at 0, and sends the next written byte as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_cmd | input | 1 | Strobe that issues START on an idle bus |
| stop_cmd | input | 1 | Strobe that issues STOP while parked |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | 8 | Byte written to the buffer |
| buf_rd | input | 1 | Buffer read strobe; marks the received byte as taken |
| buf_rdata | output | 8 | Last received byte |
| mode_rd | input | 1 | Direction bit used for the address byte (1 = read) |
| rx_nack | input | 1 | Acknowledge level sent after a received byte (1 = refuse) |
| flag_clr | input | 4 | Write-1-to-clear strobes for the flags |
| busy | output | 1 | Byte transfer in progress |
| txd_flag | output | 1 | Sent byte finished |
| rxd_flag | output | 1 | Received byte loaded |
| nack_flag | output | 1 | Slave refused a sent byte |
| ovr_flag | output | 1 | Byte arrived while buffer unread |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
Two events can land on the same clock edge: the eighth SCL falling edge that completes a received byte, and a buffer read or flag clear from software. The bench waits for the eighth rising edge of SCL, counts `HALF_DIV` clocks, and pulses `buf_rd` together with the `rxd_flag` clear so that they meet the completion edge. It then requires that no overrun is recorded, that the new byte is in the buffer, and that `rxd_flag` still reads 1. The opposite outcome is exercised as well: an unread byte followed by a second completion must stall SCL until a read arrives.

// File: rtl/i2c_byte_pkg.sv
package i2c_byte_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int FLAG_N = 4;

    // flag vector positions (match flag_clr bits)
    localparam int F_TXD  = 0;
    localparam int F_RXD  = 1;
    localparam int F_NACK = 2;
    localparam int F_OVR  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_PARK,
        ST_TX,
        ST_TACK,
        ST_RX,
        ST_RACK,
        ST_HOLD,
        ST_STOP
    } ibm_state_e;

    typedef struct packed {
        ibm_state_e          st;
        logic                scl_low;
        logic                sda_low;
        logic [BYTE_W-1:0]   sh;
        logic [BIT_W-1:0]    bitn;
        logic [BYTE_W-1:0]   rbuf;
        logic                rfull;
        logic                addr_next;
        logic                rd_mode;
        logic                ackbit;
        logic                busy;
    } ibm_regs_t;

    localparam ibm_regs_t REGS_RST = '{st: ST_IDLE, default: '0};

endpackage

// File: rtl/i2c_phase_tick.sv
module i2c_phase_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(HALF_DIV - 1));

    always_comb begin
        if (sync || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_sticky_flags.sv
module i2c_sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    logic [N-1:0] q_d, q_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        // a set in the same cycle as a clear keeps the flag at 1
        always_comb q_d[g] = set[g] | (q_q[g] & ~clr[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_byte_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] buf_rdata,
    input  logic              mode_rd,
    input  logic              rx_nack,
    input  logic [FLAG_N-1:0] flag_clr,
    output logic              busy,
    output logic              txd_flag,
    output logic              rxd_flag,
    output logic              nack_flag,
    output logic              ovr_flag,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    ibm_regs_t         r_d, r_q;
    ibm_state_e        st_w;
    logic              tick, sync;
    logic [FLAG_N-1:0] fset, flags;
    logic [BYTE_W-1:0] load_byte;

    i2c_phase_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .sync (sync),
        .tick (tick)
    );

    i2c_sticky_flags #(.N(FLAG_N)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (fset),
        .clr  (flag_clr),
        .q    (flags)
    );

    // address byte: 7 address bits then the direction bit
    assign load_byte = r_q.addr_next ? {buf_wdata[BYTE_W-2:0], mode_rd} : buf_wdata;

    always_comb begin
        r_d  = r_q;
        fset = '0;
        sync = 1'b0;
        if (buf_rd) r_d.rfull = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.scl_low = 1'b0;
                r_d.sda_low = 1'b0;
                if (start_cmd) begin
                    r_d.st = ST_START;
                    sync   = 1'b1;
                end
            end
            ST_START: if (tick) begin
                if (!r_q.sda_low) begin
                    r_d.sda_low = 1'b1;
                end else begin
                    r_d.scl_low   = 1'b1;
                    r_d.addr_next = 1'b1;
                    r_d.st        = ST_PARK;
                end
            end
            ST_PARK: begin
                if (buf_wr && !r_q.busy) begin
                    r_d.sh      = load_byte;
                    r_d.sda_low = !load_byte[BYTE_W-1];
                    r_d.bitn    = '0;
                    r_d.busy    = 1'b1;
                    r_d.st      = ST_TX;
                    sync        = 1'b1;
                    if (r_q.addr_next) r_d.rd_mode = mode_rd;
                end else if (stop_cmd) begin
                    r_d.sda_low = 1'b1;
                    r_d.st      = ST_STOP;
                    sync        = 1'b1;
                end
            end
            ST_TX: if (tick) begin
                if (r_q.scl_low) begin
                    r_d.scl_low = 1'b0;
                end else begin
                    r_d.scl_low = 1'b1;
                    if (r_q.bitn == BIT_LAST) begin
                        r_d.sda_low = 1'b0;
                        r_d.st      = ST_TACK;
                    end else begin
                        r_d.sh      = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.sda_low = !r_q.sh[BYTE_W-2];
                        r_d.bitn    = r_q.bitn + BIT_W'(1);
                    end
                end
            end
            ST_TACK: if (tick) begin
                if (r_q.scl_low) begin
                    r_d.scl_low = 1'b0;
                    r_d.ackbit  = sda_in;
                end else begin
                    r_d.scl_low   = 1'b1;
                    fset[F_NACK]  = r_q.ackbit;
                    fset[F_TXD]   = 1'b1;
                    r_d.busy      = 1'b0;
                    r_d.addr_next = 1'b0;
                    if (r_q.addr_next && r_q.rd_mode && !r_q.ackbit) begin
                        r_d.busy    = 1'b1;
                        r_d.bitn    = '0;
                        r_d.sda_low = 1'b0;
                        r_d.st      = ST_RX;
                    end else begin
                        r_d.sda_low = 1'b1;
                        r_d.st      = ST_PARK;
                    end
                end
            end
            ST_RX: if (tick) begin
                if (r_q.scl_low) begin
                    r_d.scl_low = 1'b0;
                    r_d.sh      = {r_q.sh[BYTE_W-2:0], sda_in};
                end else begin
                    r_d.scl_low = 1'b1;
                    if (r_q.bitn != BIT_LAST) begin
                        r_d.bitn = r_q.bitn + BIT_W'(1);
                    end else if (r_q.rfull && !buf_rd) begin
                        fset[F_OVR] = 1'b1;
                        r_d.st      = ST_HOLD;
                    end else begin
                        r_d.rbuf    = r_q.sh;
                        r_d.rfull   = 1'b1;
                        fset[F_RXD] = 1'b1;
                        r_d.ackbit  = rx_nack;
                        r_d.sda_low = !rx_nack;
                        r_d.st      = ST_RACK;
                    end
                end
            end
            ST_HOLD: if (buf_rd) begin
                r_d.rbuf    = r_q.sh;
                r_d.rfull   = 1'b1;
                fset[F_RXD] = 1'b1;
                r_d.ackbit  = rx_nack;
                r_d.sda_low = !rx_nack;
                r_d.st      = ST_RACK;
                sync        = 1'b1;
            end
            ST_RACK: if (tick) begin
                if (r_q.scl_low) begin
                    r_d.scl_low = 1'b0;
                end else begin
                    r_d.scl_low = 1'b1;
                    if (r_q.ackbit) begin
                        r_d.busy    = 1'b0;
                        r_d.sda_low = 1'b1;
                        r_d.st      = ST_PARK;
                    end else begin
                        r_d.bitn    = '0;
                        r_d.sda_low = 1'b0;
                        r_d.st      = ST_RX;
                    end
                end
            end
            ST_STOP: if (tick) begin
                if (r_q.scl_low) begin
                    r_d.scl_low = 1'b0;
                end else begin
                    r_d.sda_low = 1'b0;
                    r_d.st      = ST_IDLE;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign st_w      = r_q.st;
    assign scl_oe    = r_q.scl_low;
    assign sda_oe    = r_q.sda_low;
    assign busy      = r_q.busy;
    assign buf_rdata = r_q.rbuf;
    assign txd_flag  = flags[F_TXD];
    assign rxd_flag  = flags[F_RXD];
    assign nack_flag = flags[F_NACK];
    assign ovr_flag  = flags[F_OVR];
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk
    import i2c_byte_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input ibm_state_e        st,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              busy,
    input logic              buf_wr,
    input logic              nack_flag,
    input logic              ovr_flag,
    input logic              rxd_flag,
    input logic              rx_nack,
    input logic [BYTE_W-1:0] buf_rdata
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!scl_oe && !sda_oe)); // R1

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
        |-> ($past(st) == ST_START || $past(st) == ST_STOP)); // R4

    AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(buf_wr)); // R5

    AST_NACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_flag) |-> !busy); // R6

    AST_ACK_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxd_flag) |-> (sda_oe == !$past(rx_nack))); // R8

    AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> scl_oe); // R9

    AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $stable(buf_rdata)); // R9
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st_w),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .buf_wr   (buf_wr),
    .nack_flag(nack_flag),
    .ovr_flag (ovr_flag),
    .rxd_flag (rxd_flag),
    .rx_nack  (rx_nack),
    .buf_rdata(buf_rdata)
);

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_cmd = 1'b0, stop_cmd = 1'b0;
    logic       buf_wr = 1'b0, buf_rd = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic       mode_rd = 1'b0, rx_nack = 1'b0;
    logic [3:0] flag_clr = '0;
    logic       busy, txd_flag, rxd_flag, nack_flag, ovr_flag;
    logic       scl_oe, sda_oe;
    logic       slave_low = 1'b0;
    logic       scl_line, sda_line;

    int n_chk = 0;
    int n_bad = 0;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe | slave_low);

    always #10 clk = ~clk;

    i2c_byte_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .mode_rd(mode_rd), .rx_nack(rx_nack), .flag_clr(flag_clr), .busy(busy),
        .txd_flag(txd_flag), .rxd_flag(rxd_flag), .nack_flag(nack_flag), .ovr_flag(ovr_flag),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_high(output int n);
        n = 0;
        while (!scl_line) begin @(negedge clk); n++; end
    endtask

    task automatic wait_low(output int n);
        n = 0;
        while (scl_line) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_clr(input logic [3:0] v);
        @(negedge clk); flag_clr = v;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); buf_rd = 1'b1;
        @(negedge clk); buf_rd = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
        while (!sda_oe) @(negedge clk);
        chk("R2 start: SCL high when SDA falls", scl_line, 1);
        while (scl_line) @(negedge clk);
        chk("R2 start: SDA still low when SCL falls", sda_line, 0);
    endtask

    task automatic do_stop();
        @(negedge clk); stop_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0;
        while (!scl_line) @(negedge clk);
        chk("R2 stop: SDA low when SCL released", sda_line, 0);
        while (!sda_line) @(negedge clk);
        chk("R2 stop: SCL high when SDA released", scl_line, 1);
    endtask

    // write a byte, capture it on the wire, answer with ack_low
    task automatic tx_byte(input logic [7:0] w, input logic m, input logic ack_low,
                           input logic poke, output logic [7:0] got,
                           output int hi_len, output int lo_len);
        int n;
        got = '0; hi_len = 0; lo_len = 0;
        @(negedge clk); buf_wdata = w; mode_rd = m; buf_wr = 1'b1;
        @(negedge clk); buf_wr = 1'b0;
        chk("R5 busy after accepted write", busy, 1);
        for (int i = 0; i < 8; i++) begin
            wait_high(n);
            if (i == 4) lo_len = n;
            got = {got[6:0], sda_line};
            if (poke && i == 1) begin
                buf_wdata = 8'h11; buf_wr = 1'b1;
                @(negedge clk); buf_wr = 1'b0;
            end
            wait_low(n);
            if (i == 3) hi_len = n;
        end
        slave_low = ack_low;
        wait_high(n);
        wait_low(n);
        slave_low = 1'b0;
    endtask

    // slave drives a byte; optional read+rxd clear on the completion edge
    task automatic rx_byte(input logic [7:0] b, input logic timed);
        int n;
        for (int i = 7; i >= 0; i--) begin
            slave_low = !b[i];
            wait_high(n);
            if (i == 0 && timed) begin
                repeat (HALF - 1) @(negedge clk);
                buf_rd = 1'b1; flag_clr = 4'b0010;
                @(negedge clk);
                buf_rd = 1'b0; flag_clr = '0;
            end
            wait_low(n);
        end
        slave_low = 1'b0;
    endtask

    task automatic rx_ack(output logic a);
        int n;
        wait_high(n);
        a = sda_line;
        wait_low(n);
    endtask

    task automatic t_reset();
        chk("R1 scl_oe after reset", scl_oe, 0);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 busy after reset", busy, 0);
        chk("R1 flags after reset", {txd_flag, rxd_flag, nack_flag, ovr_flag}, 0);
        repeat (5) @(negedge clk);
        chk("R1 bus released while idle", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_write_path();
        logic [7:0] got;
        int hi, lo;
        do_start();
        tx_byte(8'h5A, 1'b0, 1'b1, 1'b0, got, hi, lo);
        chk("R3 address byte on wire", got, 8'hB4);
        chk("R6 txd set", txd_flag, 1);
        chk("R6 nack clear on ack", nack_flag, 0);
        chk("R6 busy cleared", busy, 0);
        chk("R6 master keeps SDA", sda_oe, 1);
        pulse_clr(4'b0001);
        chk("R11 txd cleared by flag_clr[0]", txd_flag, 0);
        tx_byte(8'hC3, 1'b0, 1'b0, 1'b1, got, hi, lo);
        chk("R5 write while busy ignored", got, 8'hC3);
        chk("R4 SCL high phase length", hi, HALF);
        chk("R4 SCL low phase length", lo, HALF);
        chk("R6 nack set on refusal", nack_flag, 1);
        chk("R6 txd set after data", txd_flag, 1);
        chk("R6 busy cleared after data", busy, 0);
        pulse_clr(4'b1111);
        chk("R11 all flags cleared", {txd_flag, rxd_flag, nack_flag, ovr_flag}, 0);
        do_stop();
    endtask

    task automatic t_nack_read_addr();
        logic [7:0] got;
        int hi, lo;
        do_start();
        tx_byte(8'h21, 1'b1, 1'b0, 1'b0, got, hi, lo);
        chk("R3 read address byte", got, 8'h43);
        chk("R12 nack after refused read address", nack_flag, 1);
        chk("R12 busy 0 after refused read address", busy, 0);
        chk("R12 SDA kept low", sda_oe, 1);
        pulse_clr(4'b1111);
        tx_byte(8'h7E, 1'b0, 1'b1, 1'b0, got, hi, lo);
        chk("R12 data byte sent after refusal", got, 8'h7E);
        chk("R12 txd after data", txd_flag, 1);
        pulse_clr(4'b1111);
        do_stop();
    endtask

    task automatic t_read_path();
        logic [7:0] got;
        logic a;
        int hi, lo;
        rx_nack = 1'b0;
        do_start();
        tx_byte(8'h33, 1'b1, 1'b1, 1'b0, got, hi, lo);
        chk("R3 read address on wire", got, 8'h67);
        chk("R7 busy held after read address", busy, 1);
        chk("R7 SDA released", sda_oe, 0);
        rx_byte(8'hA5, 1'b0);
        chk("R8 rxd set", rxd_flag, 1);
        chk("R7 byte shifted MSB first", buf_rdata, 8'hA5);
        rx_ack(a);
        chk("R8 ack level sent", a, 0);
        chk("R8 still busy after ack", busy, 1);
        rx_byte(8'h3C, 1'b0);
        chk("R9 overrun flagged", ovr_flag, 1);
        chk("R9 buffer keeps older byte", buf_rdata, 8'hA5);
        repeat (3 * HALF) @(negedge clk);
        chk("R9 SCL held low on overrun", scl_oe, 1);
        @(negedge clk); buf_rd = 1'b1;
        chk("R9 read returns older byte", buf_rdata, 8'hA5);
        @(negedge clk); buf_rd = 1'b0;
        chk("R9 held byte loaded on read", buf_rdata, 8'h3C);
        pulse_clr(4'b1010);
        rx_ack(a);
        chk("R9 held byte acknowledged", a, 0);
        rx_byte(8'h96, 1'b1);
        chk("R10 no overrun on same-cycle read", ovr_flag, 0);
        chk("R10 new byte loaded", buf_rdata, 8'h96);
        chk("R11 set wins over clear", rxd_flag, 1);
        rx_nack = 1'b1;
        pulse_rd();
        rx_ack(a);
        chk("R8 ack after 0x96", a, 0);
        rx_byte(8'h0F, 1'b0);
        chk("R8 last byte loaded", buf_rdata, 8'h0F);
        chk("R9 no overrun after read", ovr_flag, 0);
        rx_ack(a);
        chk("R8 refusal level sent", a, 1);
        chk("R8 busy cleared after refusal", busy, 0);
        chk("R8 parks with SDA low", sda_oe, 1);
        rx_nack = 1'b0;
        do_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_path();
        t_nack_read_addr();
        t_read_path();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule